// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller With Fault Detection

This block moves one byte at a time across a four-wire synchronous serial link and works either as the clock-driving master or as a slave that follows an external clock. A host reaches it through three byte registers (control, status, data) chosen by a two-bit selector, and gets an interrupt when a byte has moved or a bus fault has occurred. One shift register sends a byte while the byte coming back is collected, and the finished byte goes into a separate read buffer.

As master, the block makes the serial clock from the system clock with a selectable divider and starts a transfer when the host writes the data register. As slave, it samples the external clock, data and select through synchronizers and moves one bit per clock edge pair. It flags host writes that land in the middle of a transfer and throws out those bytes. If a master sees its select input pulled low, it reports a mode fault and drops off the bus at once. A freeze input holds every register where it is.

Top module: `spi_port`

## Requirements
- R1: Register select 0 is control, 1 is status and 2 is data. Control bits: 7 interrupt enable, 6 enable, 5 master, 4 clock idle level (polarity), 3 phase, 2:0 rate. Status bits: 7 done, 6 write collision, 4 mode fault, all others 0. After reset, control and status read 00h, irq is low and no output enable is high.
- R2: A transfer moves eight bits each way MSB first, and the received byte is then readable from the data register. With loopback (MISO tied to MOSI) the byte read back equals the byte sent.
- R3: When phase is 0, data is captured on odd clock edges. When phase is 1, it is captured on even edges. Both phases deliver the correct byte for both polarities.
- R4: In master mode SCK rests at the polarity level when idle and makes exactly 16 transitions per transfer. Done is set 16·H system cycles after the data write, where H = 2<<rate and rate values 6 and 7 act as 5, giving dividers 4 to 128.
- R5: In slave mode the rate field has no effect, and each bit is timed only by the sckIn pin.
- R6: The end of a transfer sets done. irq = interrupt enable AND (done OR mode fault). Done is cleared by a status read followed by a data register access.
- R7: A data write during a transfer sets write collision. The write is discarded and the transfer in progress completes with its original byte. The flag clears through the same sequence as done.
- R8: ssN low while enabled as master sets mode fault and clears the enable and master bits, which turns off the SCK and MOSI drivers. A status read followed by a control write clears the fault.
- R9: While freeze is high, no register changes: host writes are ignored and SCK stops. The transfer resumes correctly once freeze drops.
- R10: In slave mode misoOe follows ssN with no clock delay. With phase 0, MISO carries the MSB of the loaded byte as soon as ssN falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Holds all state while high |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (flag-clear side effects) |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Selected register contents |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock in (slave) |
| sckOut | output | 1 | Serial clock out (master) |
| sckOe | output | 1 | Serial clock output enable |
| mosiIn | input | 1 | Serial data in (slave) |
| mosiOut | output | 1 | Serial data out (master) |
| mosiOe | output | 1 | MOSI output enable |
| misoIn | input | 1 | Serial data in (master) |
| misoOut | output | 1 | Serial data out (slave) |
| misoOe | output | 1 | MISO output enable |
| ssN | input | 1 | Active-low select |

## Verification
The bench builds the block with its defaults: six divider steps and two synchronizer stages. With six steps, every rate code can be reached in a short run, so it can measure transfer lengths from the /4 divider up through the clamped /128 codes. With two synchronizer stages, the slave sees a three-cycle delay from pin to action. A half period of eight system cycles on the bench-driven slave clock is enough to show both phases capturing correctly, and MISO can be checked the instant select falls.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int EDGES  = 2 * BYTE_W;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CTL_IRQ  = 7;
  localparam int CTL_EN   = 6;
  localparam int CTL_MST  = 5;
  localparam int CTL_CPOL = 4;
  localparam int CTL_CPHA = 3;

  localparam int STA_DONE  = 7;
  localparam int STA_WCOL  = 6;
  localparam int STA_FAULT = 4;

  typedef struct packed {
    logic load;      // take host byte into the shift register
    logic shiftOut;  // advance transmit register by one bit
    logic sampleIn;  // capture one received bit
    logic finish;    // last edge: publish received byte
  } dpStrobe_t;
endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              inBit,
  output logic              txBit,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] rxNext;
  logic [BYTE_W-1:0] readBuf;

  assign rxNext = strobe.sampleIn ? {rxShift[BYTE_W-2:0], inBit} : rxShift;
  assign txBit  = txShift[BYTE_W-1];
  assign rxByte = readBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      readBuf <= '0;
    end else begin
      if (strobe.load)
        txShift <= wrData;
      else if (strobe.shiftOut)
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      rxShift <= rxNext;
      if (strobe.finish)
        readBuf <= rxNext;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DIV_STEPS   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              freeze,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        regSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq,
  output logic              sckOut,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic [BYTE_W-1:0] statusQ,
  output logic              xferActive,
  output dpStrobe_t         strobe,
  output logic              inBit
);
  localparam int MAX_RATE = DIV_STEPS - 1;
  localparam int DIV_W    = $clog2(2 << MAX_RATE);
  localparam int CNT_W    = $clog2(EDGES + 1);

  logic [SYNC_STAGES-1:0] sckSync, mosiSync, ssSync;
  logic sckPrev;
  logic doneQ, wcolQ, faultQ, doneArm, faultArm;
  logic mBusy, sckLevel;
  logic [CNT_W-1:0] edgeCnt, edgeNum;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0]   halfLen;
  logic [2:0]       rateEff;

  logic isMaster, isSlave, cpha, cpol, ssLow, slaveSel;
  logic divHit, edgeEv, oddEdge, lastEdge;
  logic wrCtrl, wrDat, rdStat, rdDat, dataAcc, faultEv, dataAccept, startM;

  assign isMaster = ctrlQ[CTL_EN] & ctrlQ[CTL_MST];
  assign isSlave  = ctrlQ[CTL_EN] & ~ctrlQ[CTL_MST];
  assign cpha     = ctrlQ[CTL_CPHA];
  assign cpol     = ctrlQ[CTL_CPOL];
  assign ssLow    = ~ssSync[SYNC_STAGES-1];
  assign slaveSel = isSlave & ssLow;

  assign rateEff = (ctrlQ[2:0] > 3'(MAX_RATE)) ? 3'(MAX_RATE) : ctrlQ[2:0];
  assign halfLen = (DIV_W+1)'(2) << rateEff;
  assign divHit  = ({1'b0, divCnt} == halfLen - (DIV_W+1)'(1));

  assign edgeEv   = ~freeze & (isMaster ? (mBusy & divHit)
                                        : (slaveSel & (sckSync[SYNC_STAGES-1] ^ sckPrev)));
  assign edgeNum  = edgeCnt + CNT_W'(1);
  assign oddEdge  = edgeNum[0];
  assign lastEdge = (edgeNum == CNT_W'(EDGES));

  assign xferActive = isMaster ? mBusy : (isSlave & (edgeCnt != '0));

  assign wrCtrl  = ~freeze & wrEn & (regSel == SEL_CTRL);
  assign wrDat   = ~freeze & wrEn & (regSel == SEL_DATA);
  assign rdStat  = ~freeze & rdEn & (regSel == SEL_STAT);
  assign rdDat   = ~freeze & rdEn & (regSel == SEL_DATA);
  assign dataAcc = wrDat | rdDat;
  assign faultEv = ~freeze & isMaster & ssLow;
  assign dataAccept = wrDat & ~xferActive;
  assign startM  = dataAccept & isMaster & ~faultEv;

  assign strobe.load     = dataAccept;
  assign strobe.shiftOut = edgeEv & (cpha ? (oddEdge & (edgeNum != CNT_W'(1))) : ~oddEdge);
  assign strobe.sampleIn = edgeEv & (cpha ? ~oddEdge : oddEdge);
  assign strobe.finish   = edgeEv & lastEdge;

  assign inBit   = isMaster ? misoIn : mosiSync[SYNC_STAGES-1];
  assign statusQ = {doneQ, wcolQ, 1'b0, faultQ, 4'b0000};
  assign irq     = ctrlQ[CTL_IRQ] & (doneQ | faultQ);
  assign sckOut  = mBusy ? sckLevel : cpol;

  always_comb begin
    case (regSel)
      SEL_CTRL: rdData = ctrlQ;
      SEL_STAT: rdData = statusQ;
      SEL_DATA: rdData = rxByte;
      default:  rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      ssSync   <= '1;
      sckPrev  <= 1'b0;
      ctrlQ    <= '0;
      doneQ    <= 1'b0;
      wcolQ    <= 1'b0;
      faultQ   <= 1'b0;
      doneArm  <= 1'b0;
      faultArm <= 1'b0;
      mBusy    <= 1'b0;
      sckLevel <= 1'b0;
      edgeCnt  <= '0;
      divCnt   <= '0;
    end else if (!freeze) begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      ssSync   <= {ssSync[SYNC_STAGES-2:0], ssN};
      sckPrev  <= sckSync[SYNC_STAGES-1];

      if (wrCtrl) ctrlQ <= wrData;
      if (faultEv) begin
        ctrlQ[CTL_EN]  <= 1'b0;
        ctrlQ[CTL_MST] <= 1'b0;
      end

      if (faultEv) faultQ <= 1'b1;
      else if (wrCtrl && faultArm) faultQ <= 1'b0;
      if (rdStat) faultArm <= faultQ;
      else if (wrCtrl) faultArm <= 1'b0;

      if (strobe.finish) doneQ <= 1'b1;
      else if (dataAcc && doneArm) doneQ <= 1'b0;
      if (wrDat && xferActive) wcolQ <= 1'b1;
      else if (dataAcc && doneArm) wcolQ <= 1'b0;
      if (rdStat) doneArm <= doneQ | wcolQ;
      else if (dataAcc) doneArm <= 1'b0;

      if (!isMaster || faultEv) mBusy <= 1'b0;
      else if (startM) mBusy <= 1'b1;
      else if (strobe.finish) mBusy <= 1'b0;

      if (!(isMaster ? mBusy : slaveSel)) edgeCnt <= '0;
      else if (edgeEv) edgeCnt <= lastEdge ? '0 : edgeNum;

      if (!mBusy || divHit) divCnt <= '0;
      else divCnt <= divCnt + DIV_W'(1);

      if (!mBusy) sckLevel <= cpol;
      else if (edgeEv) sckLevel <= ~sckLevel;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_STEPS   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freeze,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  input  logic       mosiIn,
  output logic       mosiOut,
  output logic       mosiOe,
  input  logic       misoIn,
  output logic       misoOut,
  output logic       misoOe,
  input  logic       ssN
);
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] ctrlQ, statusQ, rxByte;
  logic              xferActive, inBit, txBit;

  spi_port_ctrl #(.DIV_STEPS(DIV_STEPS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .freeze(freeze), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .sckIn(sckIn), .mosiIn(mosiIn),
    .misoIn(misoIn), .ssN(ssN), .rxByte(rxByte), .rdData(rdData), .irq(irq),
    .sckOut(sckOut), .ctrlQ(ctrlQ), .statusQ(statusQ), .xferActive(xferActive),
    .strobe(strobe), .inBit(inBit)
  );

  spi_port_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .inBit(inBit), .txBit(txBit), .rxByte(rxByte)
  );

  assign sckOe   = ctrlQ[CTL_EN] & ctrlQ[CTL_MST];
  assign mosiOe  = sckOe;
  assign mosiOut = txBit;
  assign misoOut = txBit;
  assign misoOe  = ctrlQ[CTL_EN] & ~ctrlQ[CTL_MST] & ~ssN;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       freeze,
  input logic       wrEn,
  input logic [1:0] regSel,
  input logic [7:0] ctrlQ,
  input logic [7:0] statusQ,
  input logic [7:0] rxByte,
  input logic       sckOut,
  input logic       sckOe,
  input logic       irq
);
  // R7
  wcol_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[6]) |-> $past(wrEn && regSel == 2'd2));

  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[7] && statusQ[7]) |-> irq);

  // R8
  fault_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[4]) |-> (!sckOe && ctrlQ[6:5] == 2'b00 && $past(ctrlQ[6:5] == 2'b11)));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(ctrlQ) && $stable(statusQ) && $stable(rxByte) && $stable(sckOut)));

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusQ[7]) && sckOe) |-> (sckOut == ctrlQ[4]));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rstN(rstN), .freeze(freeze), .wrEn(wrEn), .regSel(regSel),
  .ctrlQ(ctrlQ), .statusQ(statusQ), .rxByte(rxByte), .sckOut(sckOut),
  .sckOe(sckOe), .irq(irq)
);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freeze = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic irq, sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssN = 1'b1;
  logic loopMode = 1'b1, misoDrv = 1'b0;
  logic misoIn;
  int checks = 0, errors = 0;

  assign misoIn = loopMode ? mosiOut : misoDrv;
  always #4 clk = ~clk;

  spi_port uut (
    .clk(clk), .rstN(rstN), .freeze(freeze), .regSel(regSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .ssN(ssN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; wrData = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1 val = rdData;
  endtask

  task automatic waitDone(output int n, output int toggles);
    logic [7:0] s;
    logic lastSck;
    n = 0; toggles = 0; lastSck = sckOut;
    peek(2'd1, s);
    while (!s[7] && n < 5000) begin
      @(negedge clk);
      n++;
      if (sckOut != lastSck) toggles++;
      lastSck = sckOut;
      peek(2'd1, s);
    end
  endtask

  task automatic clearFlags();
    logic [7:0] v;
    regRead(2'd1, v);
    regRead(2'd2, v);
  endtask

  task automatic testReset();
    logic [7:0] v;
    peek(2'd0, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    peek(2'd1, v); chk(v == 8'h00, "R1 status reset", v, 0);
    chk(!irq && !sckOe && !mosiOe && !misoOe, "R1 outputs reset",
        {irq, sckOe, mosiOe, misoOe}, 0);
  endtask

  task automatic masterXfer(input int rate, input bit pol, input bit pha,
                            input logic [7:0] tx, input bit loop, input logic [7:0] expRx);
    int n, tg, h;
    logic [7:0] v;
    h = 2 << ((rate > 5) ? 5 : rate);
    loopMode = loop;
    regWrite(2'd0, {3'b111, pol, pha, 3'(rate)});
    chk(sckOut == pol, "R4 idle level", sckOut, pol);
    regWrite(2'd2, tx);
    waitDone(n, tg);
    chk(n >= 16*h && n <= 16*h + 1, "R4 transfer length", n, 16*h);
    chk(tg == 16, "R4 sck transitions", tg, 16);
    chk(sckOut == pol, "R4 back to idle", sckOut, pol);
    chk(irq, "R6 irq on done", irq, 1);
    regRead(2'd1, v);
    regRead(2'd2, v);
    chk(v == expRx, pha ? "R3 R2 rx phase1" : "R3 R2 rx phase0", v, expRx);
    peek(2'd1, v);
    chk(v[7] == 1'b0 && !irq, "R6 done cleared", v, 0);
  endtask

  task automatic slaveXfer(input bit pol, input bit pha, input logic [7:0] tx,
                           input logic [7:0] rxIn);
    logic [7:0] got, v;
    regWrite(2'd0, {3'b010, pol, pha, 3'b111});  // R5: rate 7 must not matter
    sckIn = pol;
    regWrite(2'd2, tx);
    @(negedge clk);
    ssN = 1'b0;
    #1;
    chk(misoOe, "R10 misoOe on select", misoOe, 1);
    if (!pha) chk(misoOut == tx[7], "R10 first bit at select", misoOut, tx[7]);
    repeat (4) @(negedge clk);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        mosiIn = rxIn[i];
        repeat (8) @(negedge clk);
        got[i] = misoOut;
        sckIn = ~sckIn;
        repeat (8) @(negedge clk);
        sckIn = ~sckIn;
      end else begin
        sckIn = ~sckIn;
        mosiIn = rxIn[i];
        repeat (8) @(negedge clk);
        got[i] = misoOut;
        sckIn = ~sckIn;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(got == tx, "R5 R3 slave miso byte", got, tx);
    peek(2'd1, v);
    chk(v[7], "R6 slave done", v, 8'h80);
    regRead(2'd1, v);
    regRead(2'd2, v);
    chk(v == rxIn, "R5 R2 slave rx byte", v, rxIn);
    ssN = 1'b1;
    #1 chk(!misoOe, "R10 misoOe off on deselect", misoOe, 0);
  endtask

  task automatic testCollision();
    int n, tg;
    logic [7:0] v;
    loopMode = 1'b1;
    regWrite(2'd0, 8'h60);
    regWrite(2'd2, 8'h5A);
    repeat (10) @(negedge clk);
    regWrite(2'd2, 8'hFF);
    waitDone(n, tg);
    peek(2'd1, v);
    chk(v[6], "R7 wcol set", v, 8'hC0);
    regRead(2'd1, v);
    regRead(2'd2, v);
    chk(v == 8'h5A, "R7 original byte kept", v, 8'h5A);
    peek(2'd1, v);
    chk(v == 8'h00, "R7 wcol cleared", v, 0);
  endtask

  task automatic testFault();
    logic [7:0] v;
    regWrite(2'd0, 8'hE0);
    chk(sckOe && mosiOe, "R8 drivers on as master", {sckOe, mosiOe}, 3);
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    peek(2'd1, v); chk(v[4], "R8 fault flag", v, 8'h10);
    peek(2'd0, v); chk(v[6:5] == 2'b00, "R8 enable and master cleared", v, 8'h80);
    chk(!sckOe && !mosiOe, "R8 drivers released", {sckOe, mosiOe}, 0);
    chk(irq, "R6 irq on fault", irq, 1);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    regRead(2'd1, v);
    regWrite(2'd0, 8'h00);
    peek(2'd1, v); chk(v[4] == 1'b0 && !irq, "R8 fault cleared", v, 0);
  endtask

  task automatic testFreeze();
    int n, tg;
    logic [7:0] v;
    logic held;
    bit stable;
    loopMode = 1'b1;
    regWrite(2'd0, 8'h61);
    regWrite(2'd2, 8'hC3);
    repeat (20) @(negedge clk);
    freeze = 1'b1;
    held = sckOut;
    stable = 1'b1;
    regWrite(2'd0, 8'h00);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sckOut != held) stable = 1'b0;
    end
    peek(2'd0, v);
    chk(v == 8'h61, "R9 write ignored in freeze", v, 8'h61);
    chk(stable, "R9 sck held", stable, 1);
    freeze = 1'b0;
    waitDone(n, tg);
    regRead(2'd1, v);
    regRead(2'd2, v);
    chk(v == 8'hC3, "R9 transfer resumes", v, 8'hC3);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    masterXfer(0, 1'b0, 1'b0, 8'hA6, 1'b1, 8'hA6);
    masterXfer(2, 1'b1, 1'b1, 8'h3D, 1'b1, 8'h3D);
    misoDrv = 1'b1;
    masterXfer(1, 1'b0, 1'b1, 8'h12, 1'b0, 8'hFF);
    masterXfer(6, 1'b1, 1'b0, 8'h81, 1'b1, 8'h81);
    masterXfer(7, 1'b0, 1'b0, 8'h7E, 1'b1, 8'h7E);
    testCollision();
    testFault();
    slaveXfer(1'b0, 1'b0, 8'hA5, 8'h3C);
    slaveXfer(1'b1, 1'b1, 8'h69, 8'hD2);
    slaveXfer(1'b0, 1'b1, 8'h0F, 8'hB1);
    testFreeze();
    finishRun();
  end
endmodule